// File: doc/BRIEF.md
# GPIO Bank Blink Generator

This block produces square waves for a 32-line GPIO bank and places them on the pads of the lines that ask for them. It has two independent timing sets, A and B. Each set has a programmable high-phase length and a programmable low-phase length, both counted in clock cycles. Each set runs a free-running waveform that stays high for its high-phase length, then low for its low-phase length, and then repeats.

Every line has three controls: an output-enable bit, a blink-enable bit and a set-select bit. A line that is an output and has blink enabled drives the wave of the set it selects. Every other line drives its static output bit. A small register port writes and reads back the four duration registers.

A new duration is sampled only when a phase ends. A phase that is already running therefore keeps its length, and the new value applies from the next phase of that kind. A duration of zero counts as one cycle.

Top module: `gpio_blink_gen`

## Requirements
- R1: The duration registers are addressed by byte address `reg_addr_i[3:0]`. Bit 3 picks the set (0 = A, 1 = B), and bit 2 picks the high-phase register (0) or the low-phase register (1). A write with `reg_we_i` high takes effect at the clock edge. `reg_rdata_o` shows the addressed register in the same cycle, without a clock edge.
- R2: Reset clears all four duration registers. It also places both sets at the start of their high phase, so both waves are 1 while reset is held.
- R3: Each set's wave stays 1 for its high-phase length, then 0 for its low-phase length, and repeats. The period is the sum of the two lengths.
- R4: A duration register that holds zero gives a phase of exactly one cycle.
- R5: A duration is sampled only when the preceding phase ends. A write during a phase does not change the length of the phase that is running.
- R6: A line with `line_out_en_i` = 1 and `blink_en_i` = 1 drives the wave of set A on `pad_o` when its `blink_sel_i` bit is 0, and the wave of set B when that bit is 1.
- R7: A line with `blink_en_i` = 0 drives its `line_out_i` bit on `pad_o`.
- R8: A line with `line_out_en_i` = 0 drives its `line_out_i` bit on `pad_o`, whatever its blink-enable bit and select bit hold.
- R9: The two sets run independently. Writing one set's registers never changes the other set's wave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Write strobe for the duration registers |
| reg_addr_i | input | 4 | Byte address of a duration register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Addressed duration register |
| line_out_en_i | input | 32 | Per-line output enable (1 = output) |
| line_out_i | input | 32 | Per-line static output value |
| blink_en_i | input | 32 | Per-line blink enable |
| blink_sel_i | input | 32 | Per-line set select (0 = A, 1 = B) |
| pad_o | output | 32 | Value driven to each pad |

## Verification
A register write becomes visible on `reg_rdata_o` right after the edge that accepts it. A wave changes only at a clock edge, and `pad_o` follows that wave without any further delay. The line controls act on `pad_o` in the same cycle they change. A reference model advances at every rising edge using the inputs that were held over that edge. It queues one expected pair of pad vector and read data per cycle. A monitor then compares that pair a quarter period later, well clear of the next input change at the falling edge. Because each expectation is tied to the edge that produces it, the R5 boundary rule and the one-cycle zero phases of R4 are checked cycle by cycle.

// File: rtl/gpio_blink_pkg.sv
package gpio_blink_pkg;
  localparam int unsigned NUM_SETS = 2;
  localparam int unsigned SET_W    = 1;
  localparam int unsigned ADDR_W   = SET_W + 3;
  localparam int unsigned SEL_BIT  = 2;   // 0: high-phase reg, 1: low-phase reg

  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} phase_e;
endpackage

// File: rtl/blink_regs.sv
module blink_regs
  import gpio_blink_pkg::*;
#(
  parameter int unsigned DUR_W = 32
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [DUR_W-1:0]                  wdata_i,
  output logic [DUR_W-1:0]                  rdata_o,
  output logic [NUM_SETS-1:0][DUR_W-1:0]    on_dur_o,
  output logic [NUM_SETS-1:0][DUR_W-1:0]    off_dur_o
);
  logic [SET_W-1:0] set_idx;
  logic             sel_low;

  assign set_idx = addr_i[ADDR_W-1:3];
  assign sel_low = addr_i[SEL_BIT];

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        on_dur_o[s]  <= '0;
        off_dur_o[s] <= '0;
      end else if (we_i && set_idx == SET_W'(s)) begin
        if (sel_low) off_dur_o[s] <= wdata_i;
        else         on_dur_o[s]  <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int s = 0; s < NUM_SETS; s++) begin
      if (set_idx == SET_W'(s)) rdata_o = sel_low ? off_dur_o[s] : on_dur_o[s];
    end
  end
endmodule

// File: rtl/blink_timer.sv
module blink_timer
  import gpio_blink_pkg::*;
#(
  parameter int unsigned DUR_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DUR_W-1:0] on_dur_i,
  input  logic [DUR_W-1:0] off_dur_i,
  output logic             wave_o,
  output logic             last_o
);
  phase_e           ph_q;
  logic [DUR_W-1:0] cnt_q;
  logic [DUR_W-1:0] on_len, off_len, next_len;

  // zero duration behaves as one cycle
  assign on_len   = (on_dur_i  == '0) ? DUR_W'(1) : on_dur_i;
  assign off_len  = (off_dur_i == '0) ? DUR_W'(1) : off_dur_i;
  assign next_len = (ph_q == PH_HIGH) ? off_len : on_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_HIGH;
      cnt_q <= '0;
    end else if (cnt_q == '0) begin
      ph_q  <= (ph_q == PH_HIGH) ? PH_LOW : PH_HIGH;
      cnt_q <= next_len - DUR_W'(1);
    end else begin
      cnt_q <= cnt_q - DUR_W'(1);
    end
  end

  assign wave_o = (ph_q == PH_HIGH);
  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/blink_line_mux.sv
module blink_line_mux
  import gpio_blink_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic [NUM_SETS-1:0]  wave_i,
  input  logic [NUM_LINES-1:0] out_en_i,
  input  logic [NUM_LINES-1:0] out_i,
  input  logic [NUM_LINES-1:0] blink_en_i,
  input  logic [NUM_LINES-1:0] blink_sel_i,
  output logic [NUM_LINES-1:0] pad_o
);
  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    assign pad_o[l] = (out_en_i[l] & blink_en_i[l]) ? wave_i[blink_sel_i[l]] : out_i[l];
  end
endmodule

// File: rtl/gpio_blink_gen.sv
module gpio_blink_gen
  import gpio_blink_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned DUR_W     = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [DUR_W-1:0]     reg_wdata_i,
  output logic [DUR_W-1:0]     reg_rdata_o,
  input  logic [NUM_LINES-1:0] line_out_en_i,
  input  logic [NUM_LINES-1:0] line_out_i,
  input  logic [NUM_LINES-1:0] blink_en_i,
  input  logic [NUM_LINES-1:0] blink_sel_i,
  output logic [NUM_LINES-1:0] pad_o
);
  logic [NUM_SETS-1:0][DUR_W-1:0] on_dur, off_dur;
  logic [NUM_SETS-1:0]            wave, wave_last;

  blink_regs #(.DUR_W(DUR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .on_dur_o  (on_dur),
    .off_dur_o (off_dur)
  );

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_timer
    blink_timer #(.DUR_W(DUR_W)) u_timer (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .on_dur_i  (on_dur[s]),
      .off_dur_i (off_dur[s]),
      .wave_o    (wave[s]),
      .last_o    (wave_last[s])
    );
  end

  blink_line_mux #(.NUM_LINES(NUM_LINES)) u_mux (
    .wave_i      (wave),
    .out_en_i    (line_out_en_i),
    .out_i       (line_out_i),
    .blink_en_i  (blink_en_i),
    .blink_sel_i (blink_sel_i),
    .pad_o       (pad_o)
  );
endmodule

// File: rtl/gpio_blink_chk.sv
module gpio_blink_chk
  import gpio_blink_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned DUR_W     = 32
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [NUM_SETS-1:0]            wave,
  input logic [NUM_SETS-1:0]            wave_last,
  input logic [NUM_SETS-1:0][DUR_W-1:0] on_dur,
  input logic [NUM_SETS-1:0][DUR_W-1:0] off_dur,
  input logic [NUM_LINES-1:0]           line_out_en_i,
  input logic [NUM_LINES-1:0]           line_out_i,
  input logic [NUM_LINES-1:0]           blink_en_i,
  input logic [NUM_LINES-1:0]           blink_sel_i,
  input logic [NUM_LINES-1:0]           pad_o
);
  for (genvar k = 0; k < NUM_SETS; k++) begin : g_set
    a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wave_last[k] |=> $stable(wave[k]));
    a_r3_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wave_last[k] |=> (wave[k] != $past(wave[k])));
    a_r4_zero_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wave_last[k] && !wave[k] && on_dur[k] == '0) |=> wave_last[k]);
    a_r4_zero_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wave_last[k] && wave[k] && off_dur[k] == '0) |=> wave_last[k]);
  end

  a_r7_r8_static: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~(blink_en_i & line_out_en_i)) & (pad_o ^ line_out_i)) == '0);
  a_r6_set_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((blink_en_i & line_out_en_i & ~blink_sel_i) & (pad_o ^ {NUM_LINES{wave[0]}})) == '0);
  a_r6_set_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((blink_en_i & line_out_en_i & blink_sel_i) & (pad_o ^ {NUM_LINES{wave[1]}})) == '0);
endmodule

bind gpio_blink_gen gpio_blink_chk #(.NUM_LINES(NUM_LINES), .DUR_W(DUR_W)) u_chk (.*);

// File: tb/gpio_blink_gen_test.sv
module gpio_blink_gen_test;
  localparam int CLK_P = 10;
  localparam int NL    = 32;
  localparam int DW    = 32;

  typedef struct {
    logic [NL-1:0] pad;
    logic [DW-1:0] rd;
    string         tag;
  } item_t;

  logic          clk = 0, rst_n = 0;
  logic          we = 0;
  logic [3:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [NL-1:0] oen = '1, od = '0, ben = '1, sel = '0;
  logic [NL-1:0] pad;

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R2";
  item_t q[$];

  longint m_on[2], m_off[2], m_rem[2];
  bit     m_ph[2];

  always #(CLK_P/2) clk = ~clk;

  gpio_blink_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .line_out_en_i(oen),
    .line_out_i(od), .blink_en_i(ben), .blink_sel_i(sel), .pad_o(pad)
  );

  function automatic longint plen(longint d);
    return (d == 0) ? 1 : d;
  endfunction

  // reference model: one expected item per rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin
        m_on[k] = 0; m_off[k] = 0; m_ph[k] = 1; m_rem[k] = 1;
      end
    end else begin
      item_t it;
      for (int k = 0; k < 2; k++) begin
        m_rem[k]--;
        if (m_rem[k] == 0) begin
          m_ph[k]  = !m_ph[k];
          m_rem[k] = m_ph[k] ? plen(m_on[k]) : plen(m_off[k]);
        end
      end
      if (we) begin
        if (addr[2]) m_off[addr[3]] = longint'(wdata);
        else         m_on[addr[3]]  = longint'(wdata);
      end
      for (int l = 0; l < NL; l++)
        it.pad[l] = (oen[l] & ben[l]) ? m_ph[sel[l]] : od[l];
      it.rd  = addr[2] ? DW'(m_off[addr[3]]) : DW'(m_on[addr[3]]);
      it.tag = cur_req;
      q.push_back(it);
    end
  end

  // monitor
  always @(posedge clk) begin
    #(CLK_P/4);
    while (q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      n_chk++;
      if (pad !== e.pad || rdata !== e.rd) begin
        n_fail++;
        $display("FAIL %s pad=%h rdata=%h expected pad=%h rdata=%h",
                 e.tag, pad, rdata, e.pad, e.rd);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [DW-1:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_addr(input logic [3:0] a);
    @(negedge clk); addr = a;
  endtask

  initial begin : watchdog
    #(CLK_P * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R2: state during reset
    #(CLK_P * 2 + 2);
    n_chk++;
    if (pad !== '1 || rdata !== '0) begin
      n_fail++;
      $display("FAIL R2 reset pad=%h rdata=%h expected pad=%h rdata=%h", pad, rdata, {NL{1'b1}}, 32'h0);
    end
    @(negedge clk); rst_n = 1;

    // R4: zero durations toggle each cycle, sets split by select
    cur_req = "R4"; sel = 32'h0000FFFF;
    idle(8);

    // R1: program and read back all four registers
    cur_req = "R1";
    wr(4'h0, 32'd3); wr(4'h4, 32'd2); wr(4'h8, 32'd1); wr(4'hC, 32'd5);
    rd_addr(4'h0); rd_addr(4'h4); rd_addr(4'h8); rd_addr(4'hC); rd_addr(4'h3);

    // R3 / R9: steady waveforms of two different periods
    cur_req = "R3"; idle(30);
    cur_req = "R9"; wr(4'h8, 32'd4); idle(30);

    // R5: new length mid-phase
    cur_req = "R5"; wr(4'h0, 32'd7); idle(3); wr(4'h4, 32'd1); idle(30);

    // R6: interleaved selection
    cur_req = "R6"; sel = 32'hAAAA_AAAA; idle(20);

    // R7: blink disabled on some lines
    cur_req = "R7"; ben = 32'h0F0F_0F0F; od = 32'h1234_5678; idle(20);

    // R8: input lines ignore blink controls
    cur_req = "R8"; ben = '1; oen = 32'h00FF_00FF; sel = 32'h5555_0000; idle(20);

    // R4: zero low phase on set B
    cur_req = "R4"; oen = '1; wr(4'hC, 32'd0); rd_addr(4'hC); idle(20);

    idle(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule